// File: doc/BRIEF.md
# Tagged Packet Word Buffer Pair

This block holds the two word buffers of one Ethernet port: one carries frames from the host bus towards the line, and the other carries frames from the line towards the host bus. Each buffer stores 32 entries. An entry is a 32-bit data word plus a 4-bit tag that packs, in a single code, which bytes are valid, whether the word opens or closes a frame, and whether the line side should append a frame check sequence. Writes and reads on the two sides of a buffer happen in the same clock cycle without stalls. Each side sees the oldest stored word at once, with no request needed to bring it to the output.

The host writes outbound words together with a raw tag taken from a register field. The line side receives outbound words with the tag already decoded into lane enables and frame markers. Inbound words arrive from the line with separate markers, which the block packs into the tag. When the host pops an inbound word, the block latches that word's tag into a register field that the host can read back. Each buffer reports whether it is full or empty and how many complete frames it holds. It also keeps sticky overflow and underflow flags and has a single-cycle flush.

Top module: `eth_port_fifos`

## Requirements
- R1: Each buffer returns words and tags in the order they were accepted, with no loss or change, and holds up to DEPTH (default 32) entries.
- R2: The full output is high exactly when DEPTH entries are held. The empty output is high exactly when none are held. After reset both buffers are empty.
- R3: A write while the buffer is full is dropped, even if a read happens in the same cycle. It sets that buffer's sticky overflow flag on the next cycle.
- R4: A read while the buffer is empty is dropped, even if a write happens in the same cycle. It sets that buffer's sticky underflow flag on the next cycle.
- R5: The sticky flags stay high until the buffer's clear input is pulsed. When a new overflow or underflow and a clear happen in the same cycle, the flag stays set.
- R6: In one cycle a buffer accepts both a write, when it is not full, and a read, when it is not empty. Its fill level is then unchanged.
- R7: The packet count output equals the number of stored entries whose tag marks end of frame. A tag marks end of frame when it is 01nn, 11nn or 0010.
- R8: A flush empties the buffer, zeroes its packet count and clears both sticky flags in one cycle. Any read or write in that cycle is ignored.
- R9: Inbound line words are tagged as follows. A word without end marker gets 1000 if it has the start marker, otherwise 0000. A word with both markers gets 11nn. A word with only the end marker and the append request gets 0010, and without the request gets 01nn. In each case nn is the index of the highest set lane enable, and 0 when none is set.
- R10: Outbound tags are decoded for the line as follows. 0000 is a middle word and 1000 a start word, both with all lanes valid. 01nn is an end word with the low nn+1 lanes valid. 11nn is a start-and-end word with the low nn+1 lanes valid. 0010 is an end word with all lanes valid and the append request. Every other code decodes as 0000.
- R11: The host read-tag field shows the tag of the word the host last popped. It updates on the cycle after the pop, resets to 0000, and no other event changes it, including a flush or a dropped read.
- R12: An outbound word is stored with the raw 4-bit tag given by the host with it, and this tag is used unchanged for decoding and for the packet count.
- R13: While a buffer is not empty, the read side shows the oldest word. A word written into an empty buffer appears on the read side one cycle after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_flush | input | 1 | Flush of the outbound buffer |
| tx_clr_flags | input | 1 | Clears the outbound sticky flags |
| host_wr_en | input | 1 | Host pushes an outbound word |
| host_wr_data | input | 32 | Outbound data word |
| host_wr_tag | input | 4 | Raw tag written with the outbound word |
| line_tx_rd | input | 1 | Line pops the outbound head |
| line_tx_data | output | 32 | Outbound head data |
| line_tx_bv | output | 4 | Decoded lane enables of the outbound head |
| line_tx_sop | output | 1 | Outbound head starts a frame |
| line_tx_eop | output | 1 | Outbound head ends a frame |
| line_tx_fcs | output | 1 | Line should append a check sequence |
| tx_full | output | 1 | Outbound buffer full |
| tx_empty | output | 1 | Outbound buffer empty |
| tx_pkts | output | 6 | Complete frames in the outbound buffer |
| tx_ovf | output | 1 | Outbound sticky overflow |
| tx_unf | output | 1 | Outbound sticky underflow |
| rx_flush | input | 1 | Flush of the inbound buffer |
| rx_clr_flags | input | 1 | Clears the inbound sticky flags |
| line_rx_wr | input | 1 | Line pushes an inbound word |
| line_rx_data | input | 32 | Inbound data word |
| line_rx_bv | input | 4 | Lane enables of the inbound word |
| line_rx_sop | input | 1 | Inbound word starts a frame |
| line_rx_eop | input | 1 | Inbound word ends a frame |
| line_rx_fcs | input | 1 | Append request carried with the inbound word |
| host_rd_en | input | 1 | Host pops the inbound head |
| host_rd_data | output | 32 | Inbound head data |
| host_rd_tag | output | 4 | Tag of the word last popped by the host |
| rx_full | output | 1 | Inbound buffer full |
| rx_empty | output | 1 | Inbound buffer empty |
| rx_pkts | output | 6 | Complete frames in the inbound buffer |
| rx_ovf | output | 1 | Inbound sticky overflow |
| rx_unf | output | 1 | Inbound sticky underflow |

## Verification
Full, empty, packet count, the sticky flags and the host read-tag field are registered state. Each of them is due exactly one clock after the edge that takes the write, pop, clear or flush. The head word and its decoded fields come straight from storage, so a new head is also visible one cycle after the edge that moved the pointer. The bench sets the inputs on the falling edge and advances its queue model as if the next rising edge had already happened. It then compares every output on the following falling edge, which is exactly one register stage later.

// File: rtl/pft_pkg.sv
package pft_pkg;

    localparam int WORD_BYTES = 4;
    localparam int DATA_W     = 8 * WORD_BYTES;
    localparam int TAG_W      = 4;
    localparam int ENTRY_W    = DATA_W + TAG_W;

    // Fixed tag codes; the variable ones carry a lane index in bits [1:0]
    typedef enum logic [TAG_W-1:0] {
        TAG_MIDDLE  = 4'b0000,
        TAG_END_FCS = 4'b0010,
        TAG_START   = 4'b1000
    } tag_code_e;

    localparam logic [1:0] PFX_END    = 2'b01;
    localparam logic [1:0] PFX_SINGLE = 2'b11;

    // Line-side view of one word's control information
    typedef struct packed {
        logic [WORD_BYTES-1:0] lanes;
        logic                  sof;
        logic                  eof;
        logic                  add_fcs;
    } lane_ctl_t;

    function automatic logic [1:0] top_lane(input logic [WORD_BYTES-1:0] lanes);
        logic [1:0] idx;
        idx = 2'd0;
        for (int i = 0; i < WORD_BYTES; i++) begin
            if (lanes[i]) idx = 2'(i);
        end
        return idx;
    endfunction

    function automatic logic [WORD_BYTES-1:0] low_lanes(input logic [1:0] last);
        logic [WORD_BYTES-1:0] m;
        for (int i = 0; i < WORD_BYTES; i++) begin
            m[i] = (i <= int'(last));
        end
        return m;
    endfunction

    function automatic logic [TAG_W-1:0] tag_pack(input lane_ctl_t c);
        logic [TAG_W-1:0] t;
        if (!c.eof)         t = c.sof ? TAG_START : TAG_MIDDLE;
        else if (c.sof)     t = {PFX_SINGLE, top_lane(c.lanes)};
        else if (c.add_fcs) t = TAG_END_FCS;
        else                t = {PFX_END, top_lane(c.lanes)};
        return t;
    endfunction

    function automatic lane_ctl_t tag_unpack(input logic [TAG_W-1:0] t);
        lane_ctl_t c;
        c = '{lanes: '1, sof: 1'b0, eof: 1'b0, add_fcs: 1'b0};
        casez (t)
            4'b01??: begin
                c.eof   = 1'b1;
                c.lanes = low_lanes(t[1:0]);
            end
            4'b11??: begin
                c.sof   = 1'b1;
                c.eof   = 1'b1;
                c.lanes = low_lanes(t[1:0]);
            end
            4'b1000: c.sof = 1'b1;
            4'b0010: begin
                c.eof     = 1'b1;
                c.add_fcs = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

    function automatic logic tag_closes(input logic [TAG_W-1:0] t);
        return t[2] || (t == TAG_END_FCS);
    endfunction

endpackage

// File: rtl/pft_ram.sv
module pft_ram #(
    parameter int DEPTH = 32,
    parameter int WIDTH = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Show-ahead read: the head is visible without a request
    assign rdata = mem[raddr];

endmodule

// File: rtl/pft_ptrs.sv
module pft_ptrs #(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_ok,
    output logic          rd_ok,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          full,
    output logic          empty
);

    // One extra bit tells a wrapped (full) pointer pair from an equal one
    logic [AW:0] wp, rp;

    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
    assign empty = (wp == rp);
    assign wr_ok = wr_req && !full  && !flush;
    assign rd_ok = rd_req && !empty && !flush;
    assign waddr = wp[AW-1:0];
    assign raddr = rp[AW-1:0];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (wr_ok) wp <= wp + (AW+1)'(1);
            if (rd_ok) rp <= rp + (AW+1)'(1);
        end
    end

endmodule

// File: rtl/pft_pkt_count.sv
module pft_pkt_count #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            count <= '0;
        end else begin
            case ({inc, dec})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/pft_tag_fifo.sv
module pft_tag_fifo
    import pft_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              clr_flags,
    input  logic              wr_req,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic              rd_req,
    output logic [DATA_W-1:0] head_data,
    output logic [TAG_W-1:0]  head_tag,
    output logic              full,
    output logic              empty,
    output logic [CW-1:0]     pkt_count,
    output logic              ovf,
    output logic              unf
);

    logic              wr_ok, rd_ok;
    logic [AW-1:0]     waddr, raddr;
    logic [ENTRY_W-1:0] rd_entry;

    pft_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk    (clk),
        .rst    (rst),
        .flush  (flush),
        .wr_req (wr_req),
        .rd_req (rd_req),
        .wr_ok  (wr_ok),
        .rd_ok  (rd_ok),
        .waddr  (waddr),
        .raddr  (raddr),
        .full   (full),
        .empty  (empty)
    );

    pft_ram #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_ram (
        .clk   (clk),
        .we    (wr_ok),
        .waddr (waddr),
        .wdata ({wr_tag, wr_data}),
        .raddr (raddr),
        .rdata (rd_entry)
    );

    assign head_tag  = rd_entry[ENTRY_W-1 -: TAG_W];
    assign head_data = rd_entry[DATA_W-1:0];

    pft_pkt_count #(.CW(CW)) u_pkts (
        .clk   (clk),
        .rst   (rst),
        .flush (flush),
        .inc   (wr_ok && tag_closes(wr_tag)),
        .dec   (rd_ok && tag_closes(head_tag)),
        .count (pkt_count)
    );

    // Sticky error flags: a new event beats a clear, a flush beats both
    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ovf <= 1'b0;
            unf <= 1'b0;
        end else begin
            if (wr_req && full) ovf <= 1'b1;
            else if (clr_flags) ovf <= 1'b0;
            if (rd_req && empty) unf <= 1'b1;
            else if (clr_flags)  unf <= 1'b0;
        end
    end

endmodule

// File: rtl/eth_port_fifos.sv
module eth_port_fifos
    import pft_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tx_flush,
    input  logic                  tx_clr_flags,
    input  logic                  host_wr_en,
    input  logic [DATA_W-1:0]     host_wr_data,
    input  logic [TAG_W-1:0]      host_wr_tag,
    input  logic                  line_tx_rd,
    output logic [DATA_W-1:0]     line_tx_data,
    output logic [WORD_BYTES-1:0] line_tx_bv,
    output logic                  line_tx_sop,
    output logic                  line_tx_eop,
    output logic                  line_tx_fcs,
    output logic                  tx_full,
    output logic                  tx_empty,
    output logic [CW-1:0]         tx_pkts,
    output logic                  tx_ovf,
    output logic                  tx_unf,
    input  logic                  rx_flush,
    input  logic                  rx_clr_flags,
    input  logic                  line_rx_wr,
    input  logic [DATA_W-1:0]     line_rx_data,
    input  logic [WORD_BYTES-1:0] line_rx_bv,
    input  logic                  line_rx_sop,
    input  logic                  line_rx_eop,
    input  logic                  line_rx_fcs,
    input  logic                  host_rd_en,
    output logic [DATA_W-1:0]     host_rd_data,
    output logic [TAG_W-1:0]      host_rd_tag,
    output logic                  rx_full,
    output logic                  rx_empty,
    output logic [CW-1:0]         rx_pkts,
    output logic                  rx_ovf,
    output logic                  rx_unf
);

    // ---------------- outbound: host writes, line reads ----------------
    logic [TAG_W-1:0] tx_head_tag;
    lane_ctl_t        tx_ctl;

    pft_tag_fifo #(.DEPTH(DEPTH)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .clr_flags (tx_clr_flags),
        .wr_req    (host_wr_en),
        .wr_data   (host_wr_data),
        .wr_tag    (host_wr_tag),
        .rd_req    (line_tx_rd),
        .head_data (line_tx_data),
        .head_tag  (tx_head_tag),
        .full      (tx_full),
        .empty     (tx_empty),
        .pkt_count (tx_pkts),
        .ovf       (tx_ovf),
        .unf       (tx_unf)
    );

    assign tx_ctl      = tag_unpack(tx_head_tag);
    assign line_tx_bv  = tx_ctl.lanes;
    assign line_tx_sop = tx_ctl.sof;
    assign line_tx_eop = tx_ctl.eof;
    assign line_tx_fcs = tx_ctl.add_fcs;

    // ---------------- inbound: line writes, host reads ----------------
    lane_ctl_t        rx_ctl;
    logic [TAG_W-1:0] rx_in_tag;
    logic [TAG_W-1:0] rx_head_tag;
    logic             rx_pop;

    assign rx_ctl    = '{lanes: line_rx_bv, sof: line_rx_sop,
                         eof: line_rx_eop, add_fcs: line_rx_fcs};
    assign rx_in_tag = tag_pack(rx_ctl);

    pft_tag_fifo #(.DEPTH(DEPTH)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .clr_flags (rx_clr_flags),
        .wr_req    (line_rx_wr),
        .wr_data   (line_rx_data),
        .wr_tag    (rx_in_tag),
        .rd_req    (host_rd_en),
        .head_data (host_rd_data),
        .head_tag  (rx_head_tag),
        .full      (rx_full),
        .empty     (rx_empty),
        .pkt_count (rx_pkts),
        .ovf       (rx_ovf),
        .unf       (rx_unf)
    );

    assign rx_pop = host_rd_en && !rx_empty && !rx_flush;

    // Host-visible field holding the tag of the last popped inbound word
    always_ff @(posedge clk) begin
        if (rst)         host_rd_tag <= TAG_MIDDLE;
        else if (rx_pop) host_rd_tag <= rx_head_tag;
    end

endmodule

// File: rtl/eth_port_fifos_sva.sv
module eth_port_fifos_sva #(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          tx_flush,
    input logic          tx_clr_flags,
    input logic          host_wr_en,
    input logic          line_tx_rd,
    input logic          tx_full,
    input logic          tx_empty,
    input logic [CW-1:0] tx_pkts,
    input logic          tx_ovf,
    input logic          rx_flush,
    input logic          host_rd_en,
    input logic [3:0]    host_rd_tag,
    input logic          rx_full,
    input logic          rx_empty,
    input logic [CW-1:0] rx_pkts,
    input logic          rx_ovf,
    input logic          rx_unf
);

    assert_tx_not_full_and_empty_R2: assert property (@(posedge clk) disable iff (rst)
        !(tx_full && tx_empty));

    assert_rx_not_full_and_empty_R2: assert property (@(posedge clk) disable iff (rst)
        !(rx_full && rx_empty));

    assert_tx_overflow_sets_R3: assert property (@(posedge clk) disable iff (rst)
        (host_wr_en && tx_full && !tx_flush) |=> tx_ovf);

    assert_tx_full_holds_R3: assert property (@(posedge clk) disable iff (rst)
        (tx_full && !line_tx_rd && !tx_flush) |=> tx_full);

    assert_rx_underflow_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (host_rd_en && rx_empty && !rx_flush) |=> rx_unf);

    assert_tx_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_ovf && !tx_clr_flags && !tx_flush) |=> tx_ovf);

    assert_tx_pkts_step_R7: assert property (@(posedge clk) disable iff (rst)
        !tx_flush |=> (tx_pkts == $past(tx_pkts) || tx_pkts == $past(tx_pkts) + 1'b1
                       || tx_pkts == $past(tx_pkts) - 1'b1));

    assert_rx_pkts_bound_R7: assert property (@(posedge clk) disable iff (rst)
        rx_pkts <= CW'(DEPTH));

    assert_rx_flush_clears_R8: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (rx_empty && rx_pkts == '0 && !rx_ovf && !rx_unf));

    assert_host_tag_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !(host_rd_en && !rx_empty && !rx_flush) |=> $stable(host_rd_tag));

endmodule

bind eth_port_fifos eth_port_fifos_sva #(.DEPTH(DEPTH)) u_sva (
    .clk          (clk),
    .rst          (rst),
    .tx_flush     (tx_flush),
    .tx_clr_flags (tx_clr_flags),
    .host_wr_en   (host_wr_en),
    .line_tx_rd   (line_tx_rd),
    .tx_full      (tx_full),
    .tx_empty     (tx_empty),
    .tx_pkts      (tx_pkts),
    .tx_ovf       (tx_ovf),
    .rx_flush     (rx_flush),
    .host_rd_en   (host_rd_en),
    .host_rd_tag  (host_rd_tag),
    .rx_full      (rx_full),
    .rx_empty     (rx_empty),
    .rx_pkts      (rx_pkts),
    .rx_ovf       (rx_ovf),
    .rx_unf       (rx_unf)
);

// File: tb/tb_eth_port_fifos.sv
module tb_eth_port_fifos;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 32;
    localparam int CW         = $clog2(DEPTH + 1);
    localparam int WATCHDOG   = 150000;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic          rst;
    logic          tx_flush, tx_clr_flags, host_wr_en, line_tx_rd;
    logic [31:0]   host_wr_data;
    logic [3:0]    host_wr_tag;
    logic [31:0]   line_tx_data;
    logic [3:0]    line_tx_bv;
    logic          line_tx_sop, line_tx_eop, line_tx_fcs;
    logic          tx_full, tx_empty, tx_ovf, tx_unf;
    logic [CW-1:0] tx_pkts;
    logic          rx_flush, rx_clr_flags, line_rx_wr, host_rd_en;
    logic [31:0]   line_rx_data;
    logic [3:0]    line_rx_bv;
    logic          line_rx_sop, line_rx_eop, line_rx_fcs;
    logic [31:0]   host_rd_data;
    logic [3:0]    host_rd_tag;
    logic          rx_full, rx_empty, rx_ovf, rx_unf;
    logic [CW-1:0] rx_pkts;

    eth_port_fifos #(.DEPTH(DEPTH)) dut (.*);

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    // Reference model state
    logic [35:0] txq[$];
    logic [35:0] rxq[$];
    bit          m_tx_ovf, m_tx_unf, m_rx_ovf, m_rx_unf;
    logic [3:0]  m_last_tag;

    task automatic chk(input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] ref_pack(input logic [3:0] bv, input logic sop,
                                            input logic eop, input logic fcs);
        logic [1:0] hi;
        hi = bv[3] ? 2'd3 : bv[2] ? 2'd2 : bv[1] ? 2'd1 : 2'd0;
        if (!eop) return sop ? 4'b1000 : 4'b0000;
        if (sop)  return {2'b11, hi};
        if (fcs)  return 4'b0010;
        return {2'b01, hi};
    endfunction

    // returns {bv, sop, eop, fcs}
    function automatic logic [6:0] ref_unpack(input logic [3:0] t);
        logic [3:0] m;
        m = (t[1:0] == 2'd0) ? 4'b0001 : (t[1:0] == 2'd1) ? 4'b0011 :
            (t[1:0] == 2'd2) ? 4'b0111 : 4'b1111;
        if (t[3:2] == 2'b01) return {m, 3'b010};
        if (t[3:2] == 2'b11) return {m, 3'b110};
        if (t == 4'b1000)    return {4'b1111, 3'b100};
        if (t == 4'b0010)    return {4'b1111, 3'b011};
        return {4'b1111, 3'b000};
    endfunction

    function automatic int ends_in(input logic [35:0] q[$]);
        int n = 0;
        foreach (q[i]) if (q[i][34] || q[i][35:32] == 4'b0010) n++;
        return n;
    endfunction

    task automatic compare();
        chk("R2 R6", "tx_full",  36'(tx_full),  36'(txq.size() == DEPTH));
        chk("R2 R6", "tx_empty", 36'(tx_empty), 36'(txq.size() == 0));
        chk("R7 R8", "tx_pkts",  36'(tx_pkts),  36'(ends_in(txq)));
        chk("R3 R5 R8", "tx_ovf", 36'(tx_ovf),  36'(m_tx_ovf));
        chk("R4 R5 R8", "tx_unf", 36'(tx_unf),  36'(m_tx_unf));
        if (txq.size() != 0) begin
            chk("R1 R6 R13", "line_tx_data", 36'(line_tx_data), 36'(txq[0][31:0]));
            chk("R10 R12", "line_tx_ctl",
                36'({line_tx_bv, line_tx_sop, line_tx_eop, line_tx_fcs}),
                36'(ref_unpack(txq[0][35:32])));
        end
        chk("R2 R6", "rx_full",  36'(rx_full),  36'(rxq.size() == DEPTH));
        chk("R2 R6", "rx_empty", 36'(rx_empty), 36'(rxq.size() == 0));
        chk("R7 R8", "rx_pkts",  36'(rx_pkts),  36'(ends_in(rxq)));
        chk("R3 R5 R8", "rx_ovf", 36'(rx_ovf),  36'(m_rx_ovf));
        chk("R4 R5 R8", "rx_unf", 36'(rx_unf),  36'(m_rx_unf));
        if (rxq.size() != 0)
            chk("R1 R13", "host_rd_data", 36'(host_rd_data), 36'(rxq[0][31:0]));
        chk("R9 R11", "host_rd_tag", 36'(host_rd_tag), 36'(m_last_tag));
    endtask

    // Advance the model by the effect of the coming rising edge
    task automatic predict();
        bit f, e;
        if (tx_flush) begin
            txq.delete();
            m_tx_ovf = 0;
            m_tx_unf = 0;
        end else begin
            f = (txq.size() == DEPTH);
            e = (txq.size() == 0);
            if (host_wr_en && f) m_tx_ovf = 1; else if (tx_clr_flags) m_tx_ovf = 0;
            if (line_tx_rd && e) m_tx_unf = 1; else if (tx_clr_flags) m_tx_unf = 0;
            if (line_tx_rd && !e) void'(txq.pop_front());
            if (host_wr_en && !f) txq.push_back({host_wr_tag, host_wr_data});
        end
        if (rx_flush) begin
            rxq.delete();
            m_rx_ovf = 0;
            m_rx_unf = 0;
        end else begin
            f = (rxq.size() == DEPTH);
            e = (rxq.size() == 0);
            if (line_rx_wr && f) m_rx_ovf = 1; else if (rx_clr_flags) m_rx_ovf = 0;
            if (host_rd_en && e) m_rx_unf = 1; else if (rx_clr_flags) m_rx_unf = 0;
            if (host_rd_en && !e) m_last_tag = rxq.pop_front()[35:32];
            if (line_rx_wr && !f)
                rxq.push_back({ref_pack(line_rx_bv, line_rx_sop, line_rx_eop, line_rx_fcs),
                               line_rx_data});
        end
    endtask

    function automatic bit pick(input int pct);
        return $urandom_range(99) < pct;
    endfunction

    task automatic run(input int n, input int pw, input int pr,
                       input int pflush, input int pclr);
        for (int i = 0; i < n; i++) begin
            host_wr_en   = pick(pw);
            host_wr_data = $urandom;
            host_wr_tag  = 4'($urandom_range(15));
            line_tx_rd   = pick(pr);
            tx_flush     = pick(pflush);
            tx_clr_flags = pick(pclr);
            line_rx_wr   = pick(pw);
            line_rx_data = $urandom;
            line_rx_bv   = 4'($urandom_range(15));
            line_rx_sop  = pick(40);
            line_rx_eop  = pick(50);
            line_rx_fcs  = pick(50);
            host_rd_en   = pick(pr);
            rx_flush     = pick(pflush);
            rx_clr_flags = pick(pclr);
            predict();
            @(negedge clk);
            compare();
        end
    endtask

    initial begin
        rst = 1'b1;
        {tx_flush, tx_clr_flags, host_wr_en, line_tx_rd} = '0;
        {rx_flush, rx_clr_flags, line_rx_wr, host_rd_en} = '0;
        host_wr_data = '0; host_wr_tag = '0;
        line_rx_data = '0; line_rx_bv = '0;
        {line_rx_sop, line_rx_eop, line_rx_fcs} = '0;
        m_tx_ovf = 0; m_tx_unf = 0; m_rx_ovf = 0; m_rx_unf = 0;
        m_last_tag = 4'b0000;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare();                       // R2 reset state
        run(40, 100, 0, 0, 0);           // fill past full: R3
        run(2, 0, 0, 0, 100);            // clear flags: R5
        run(3, 100, 100, 0, 0);          // full with read and write: R3 R6
        run(40, 0, 100, 0, 0);           // drain past empty: R4
        run(2, 0, 100, 0, 100);          // underflow and clear together: R5
        run(20, 100, 0, 0, 0);
        run(1, 100, 100, 100, 0);        // flush with traffic: R8
        run(800, 60, 60, 0, 5);          // concurrent traffic: R1 R6 R7
        run(800, 80, 30, 1, 3);
        run(800, 30, 80, 1, 3);
        run(800, 100, 100, 2, 10);
        run(400, 50, 50, 5, 20);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule